// File: doc/BRIEF.md
# Return-from-Interrupt Status Restore

This block computes the machine state that a return-from-interrupt operation installs. Three words come in: the machine status word that is active now, the status word saved when the interrupt was taken, and the program counter saved at that time. The block produces the restored status word and the address to resume at. Each output carries a valid flag. An opaque pipeline context word travels alongside the operation unchanged.

Most restored status bits are copied from the saved status. A few follow their own rules:
- The hypervisor and machine-check-enable bits can only come back from the saved word while the current hypervisor bit is set.
- A transaction-state field is protected against one illegal transition.
- When the saved status selects user mode, the interrupt-enable and both translation-enable bits are forced on.

The resume address is always word aligned. The operation does not write the saved registers. Privilege checks that might block the operation sit elsewhere.

The outputs are registered, one stage deep. All status bit positions below use least-significant-first indexing of the 64-bit word: index 0 is the least significant bit.

Top module: `rfi_restore`

## Requirements
- R1: One cycle after an input is presented, restored bit 60 (hypervisor) equals current bit 60 AND saved bit 60.
- R2: Restored bit 12 (machine-check enable) equals saved bit 12 when current bit 60 is 1. Otherwise it keeps current bit 12.
- R3: The restored field [34:32] (transaction state, bit 34 most significant) equals the saved field. The one exception is a current field of 3'b010 with a saved field of 3'b000: the current field is then kept.
- R4: Restored bits 15 (interrupt enable), 5 (instruction translation) and 4 (data translation) each equal the matching saved bit ORed with saved bit 14 (user mode).
- R5: Every restored bit not named in R1 to R4 is a direct copy of the same saved bit.
- R6: The resume address equals the saved program counter with bits [1:0] forced to 0.
- R7: While reset is high, and in the first cycle after it, all outputs are zero and both valid flags are 0. From the second clock edge after reset falls, both valid flags stay 1.
- R8: The context output equals the context input of the previous cycle, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_msr | input | 64 | Currently active status word |
| saved_status | input | 64 | Status word saved at interrupt entry |
| saved_pc | input | 64 | Program counter saved at interrupt entry |
| ctx_in | input | CTX_W | Pipeline context, carried through |
| new_msr | output | 64 | Restored status word |
| new_msr_valid | output | 1 | Restored status word is valid |
| next_pc | output | 64 | Word-aligned resume address |
| next_pc_valid | output | 1 | Resume address is valid |
| ctx_out | output | CTX_W | Pipeline context, one cycle later |

## Verification
A vector table covers the hypervisor bit set and clear with opposite machine-check values. This shows whether that bit is gated by the current hypervisor state, as R2 requires, or simply copied. The table also holds transaction-state pairs on both sides of the guarded transition: 010 to 000 must be held, while 010 to 001 and 011 to 000 must load. A saved word with only the user-mode bit set shows that the OR forcing acts and that the copy path does not simply pass bits 15, 5 and 4 through. All-ones, all-zeros, alternating patterns, random words and unaligned addresses cover the copy rule and the alignment. A reset pulse in the middle of the run checks the clearing of outputs and valid flags.

// File: rtl/rfi_pkg.sv
package rfi_pkg;

    localparam int XLEN = 64;

    typedef logic [XLEN-1:0] xword_t;
    typedef logic [2:0]      tstate_t;

    // Positions of the specially treated status bits (LSB-first indices)
    localparam int HV_B  = XLEN - 1 - 3;
    localparam int ME_B  = XLEN - 1 - 51;
    localparam int TS_HI = XLEN - 1 - 29;
    localparam int TS_LO = XLEN - 1 - 31;
    localparam int EE_B  = XLEN - 1 - 48;
    localparam int PR_B  = XLEN - 1 - 49;
    localparam int IR_B  = XLEN - 1 - 58;
    localparam int DR_B  = XLEN - 1 - 59;

    localparam int NUM_FORCED = 3;
    localparam int FORCED_BITS [NUM_FORCED] = '{EE_B, IR_B, DR_B};

    // Transaction-state encodings relevant to the guard
    localparam tstate_t TS_GUARD_CUR = 3'b010;
    localparam tstate_t TS_GUARD_REQ = 3'b000;

    typedef struct packed {
        xword_t msr;
        logic   msr_ok;
        xword_t pc;
        logic   pc_ok;
    } rfi_result_t;

    function automatic xword_t special_mask();
        xword_t m;
        m = '0;
        m[HV_B] = 1'b1;
        m[ME_B] = 1'b1;
        m[TS_HI:TS_LO] = '1;
        for (int i = 0; i < NUM_FORCED; i++) m[FORCED_BITS[i]] = 1'b1;
        return m;
    endfunction

    localparam xword_t COPY_MASK = ~special_mask();

endpackage

// File: rtl/rfi_priv_merge.sv
module rfi_priv_merge (
    input  logic cur_hv,
    input  logic cur_me,
    input  logic sv_hv,
    input  logic sv_me,
    output logic new_hv,
    output logic new_me
);
    // Hypervisor state can only be dropped, never gained; machine-check
    // enable is only restorable from hypervisor state.
    always_comb begin
        new_hv = cur_hv & sv_hv;
        new_me = cur_hv ? sv_me : cur_me;
    end
endmodule

// File: rtl/rfi_ts_guard.sv
module rfi_ts_guard
    import rfi_pkg::*;
(
    input  tstate_t cur_ts,
    input  tstate_t sv_ts,
    output tstate_t new_ts
);
    logic illegal;
    always_comb begin
        illegal = (cur_ts == TS_GUARD_CUR) && (sv_ts == TS_GUARD_REQ);
        new_ts  = illegal ? cur_ts : sv_ts;
    end
endmodule

// File: rtl/rfi_addr_align.sv
module rfi_addr_align #(
    parameter int W          = 64,
    parameter int ALIGN_BITS = 2
) (
    input  logic [W-1:0] addr_in,
    output logic [W-1:0] addr_out
);
    localparam logic [W-1:0] KEEP = ~((W'(1) << ALIGN_BITS) - W'(1));
    always_comb addr_out = addr_in & KEEP;
endmodule

// File: rtl/rfi_restore.sv
module rfi_restore
    import rfi_pkg::*;
#(
    parameter int CTX_W      = 8,
    parameter int ALIGN_BITS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [XLEN-1:0]  cur_msr,
    input  logic [XLEN-1:0]  saved_status,
    input  logic [XLEN-1:0]  saved_pc,
    input  logic [CTX_W-1:0] ctx_in,
    output logic [XLEN-1:0]  new_msr,
    output logic             new_msr_valid,
    output logic [XLEN-1:0]  next_pc,
    output logic             next_pc_valid,
    output logic [CTX_W-1:0] ctx_out
);
    logic        hv_n, me_n;
    tstate_t     ts_n;
    logic [NUM_FORCED-1:0] forced_n;
    xword_t      pc_n;
    rfi_result_t res_d, res_q;
    logic [CTX_W-1:0] ctx_q;

    rfi_priv_merge u_priv (
        .cur_hv (cur_msr[HV_B]),
        .cur_me (cur_msr[ME_B]),
        .sv_hv  (saved_status[HV_B]),
        .sv_me  (saved_status[ME_B]),
        .new_hv (hv_n),
        .new_me (me_n)
    );

    rfi_ts_guard u_ts (
        .cur_ts (cur_msr[TS_HI:TS_LO]),
        .sv_ts  (saved_status[TS_HI:TS_LO]),
        .new_ts (ts_n)
    );

    rfi_addr_align #(.W(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_align (
        .addr_in  (saved_pc),
        .addr_out (pc_n)
    );

    // User mode implies interrupts and translation on
    for (genvar g = 0; g < NUM_FORCED; g++) begin : g_force
        assign forced_n[g] = saved_status[FORCED_BITS[g]] | saved_status[PR_B];
    end

    always_comb begin
        res_d.msr = saved_status & COPY_MASK;
        res_d.msr[HV_B] = hv_n;
        res_d.msr[ME_B] = me_n;
        res_d.msr[TS_HI:TS_LO] = ts_n;
        for (int i = 0; i < NUM_FORCED; i++) res_d.msr[FORCED_BITS[i]] = forced_n[i];
        res_d.msr_ok = 1'b1;
        res_d.pc     = pc_n;
        res_d.pc_ok  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            ctx_q <= '0;
        end else begin
            res_q <= res_d;
            ctx_q <= ctx_in;
        end
    end

    assign new_msr       = res_q.msr;
    assign new_msr_valid = res_q.msr_ok;
    assign next_pc       = res_q.pc;
    assign next_pc_valid = res_q.pc_ok;
    assign ctx_out       = ctx_q;
endmodule

// File: rtl/rfi_restore_chk.sv
module rfi_restore_chk
    import rfi_pkg::*;
#(
    parameter int CTX_W      = 8,
    parameter int ALIGN_BITS = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [XLEN-1:0]  cur_msr,
    input logic [XLEN-1:0]  saved_status,
    input logic [XLEN-1:0]  saved_pc,
    input logic [CTX_W-1:0] ctx_in,
    input logic [XLEN-1:0]  new_msr,
    input logic             new_msr_valid,
    input logic [XLEN-1:0]  next_pc,
    input logic             next_pc_valid,
    input logic [CTX_W-1:0] ctx_out
);
    localparam logic [XLEN-1:0] LOWM = (XLEN'(1) << ALIGN_BITS) - XLEN'(1);

    a_r1_hv_drop: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> new_msr[HV_B] == ($past(cur_msr[HV_B]) & $past(saved_status[HV_B])));

    a_r2_me_gate: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> new_msr[ME_B] == ($past(cur_msr[HV_B]) ? $past(saved_status[ME_B])
                                                         : $past(cur_msr[ME_B])));

    a_r3_ts_hold: assert property (@(posedge clk) disable iff (rst)
        (cur_msr[TS_HI:TS_LO] == TS_GUARD_CUR && saved_status[TS_HI:TS_LO] == TS_GUARD_REQ)
        |=> new_msr[TS_HI:TS_LO] == TS_GUARD_CUR);

    a_r4_user_force: assert property (@(posedge clk) disable iff (rst)
        saved_status[PR_B] |=> (new_msr[EE_B] && new_msr[IR_B] && new_msr[DR_B]));

    a_r5_copy: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (new_msr & COPY_MASK) == ($past(saved_status) & COPY_MASK));

    a_r6_align: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (next_pc & LOWM) == '0 && (next_pc & ~LOWM) == ($past(saved_pc) & ~LOWM));

    a_r7_valid: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (new_msr_valid && next_pc_valid));

    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> (!new_msr_valid && !next_pc_valid && new_msr == '0));

    a_r8_ctx: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ctx_out == $past(ctx_in));
endmodule

bind rfi_restore rfi_restore_chk #(.CTX_W(CTX_W), .ALIGN_BITS(ALIGN_BITS)) u_chk (.*);

// File: tb/rfi_restore_tb.sv
module rfi_restore_tb;
    localparam int CTX_W = 8;
    localparam int NV    = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [63:0]      cur_msr = '0, saved_status = '0, saved_pc = '0;
    logic [CTX_W-1:0] ctx_in = '0;
    logic [63:0]      new_msr, next_pc;
    logic             new_msr_valid, next_pc_valid;
    logic [CTX_W-1:0] ctx_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rfi_restore #(.CTX_W(CTX_W)) u_dut (.*);

    // {cur_msr, saved_status, saved_pc}
    localparam logic [191:0] VEC [NV] = '{
        {64'h0,                   64'h0,                   64'h0},
        {64'h1000_0000_0000_1000, 64'h1000_0000_0000_0000, 64'h0000_0000_0000_1003},
        {64'h0000_0000_0000_1000, 64'h1000_0000_0000_0000, 64'h0000_0000_0000_2001},
        {64'h0000_0002_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0004},
        {64'h0000_0002_0000_0000, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0006},
        {64'h0000_0003_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0005},
        {64'h0000_0000_0000_0000, 64'h0000_0000_0000_4000, 64'h8000_0000_0000_0002},
        {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        {64'h1000_0000_0000_0000, 64'h5555_5555_5555_5555, 64'h1234_5678_9ABC_DEF7},
        {64'hAAAA_AAAA_AAAA_AAAA, 64'h0000_0000_0000_0000, 64'hFEDC_BA98_7654_3212}
    };

    function automatic logic [63:0] ref_msr(logic [63:0] c, logic [63:0] s);
        logic [63:0] r;
        r = s;                                          // R5 default copy
        r[60] = c[60] & s[60];                          // R1
        r[12] = c[60] ? s[12] : c[12];                  // R2
        if (c[34:32] == 3'b010 && s[34:32] == 3'b000)   // R3
            r[34:32] = c[34:32];
        r[15] = s[15] | s[14];                          // R4
        r[5]  = s[5]  | s[14];
        r[4]  = s[4]  | s[14];
        return r;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [63:0] c, logic [63:0] s, logic [63:0] p, logic [CTX_W-1:0] x);
        cur_msr = c; saved_status = s; saved_pc = p; ctx_in = x;
        @(posedge clk);
        @(negedge clk);
        chk("R1-R5 msr", new_msr, ref_msr(c, s));
        chk("R6 next_pc", next_pc, {p[63:2], 2'b00});
        chk("R7 valid", {62'd0, new_msr_valid, next_pc_valid}, 64'd3);
        chk("R8 ctx", {56'd0, ctx_out}, {56'd0, x});
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R7: reset state
        chk("R7 reset msr", new_msr, 64'd0);
        chk("R7 reset valid", {62'd0, new_msr_valid, next_pc_valid}, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            apply(VEC[i][191:128], VEC[i][127:64], VEC[i][63:0], CTX_W'(i * 37 + 5));

        // R1/R2 directed: HV kept, ME loaded 0 from saved
        apply(64'h1000_0000_0000_1000, 64'h1000_0000_0000_0000, 64'h10, 8'h11);
        chk("R1 hv", {63'd0, new_msr[60]}, 64'd1);
        chk("R2 me", {63'd0, new_msr[12]}, 64'd0);
        // R3 directed: guarded transition held
        apply(64'h0000_0002_0000_0000, 64'h0, 64'h0, 8'h22);
        chk("R3 ts hold", {61'd0, new_msr[34:32]}, 64'd2);
        // R4 directed: user mode forces EE/IR/DR
        apply(64'h0, 64'h0000_0000_0000_4000, 64'h0, 8'h33);
        chk("R4 forced", {61'd0, new_msr[15], new_msr[5], new_msr[4]}, 64'd7);

        for (int i = 0; i < 200; i++)
            apply({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                  CTX_W'($urandom));

        // R7: mid-run reset clears outputs
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R7 mid reset msr", new_msr, 64'd0);
        chk("R7 mid reset pc", next_pc, 64'd0);
        chk("R7 mid reset valid", {62'd0, new_msr_valid, next_pc_valid}, 64'd0);
        rst = 1'b0;
        apply(64'h0, 64'hFFFF_0000_FFFF_0000, 64'h3, 8'hAA);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule